// File: doc/BRIEF.md
# Interrupt Security Status Register Bank

This block holds one security bit per interrupt line and makes those bits readable and writable through a simple register bus. A bit value of 0 marks an interrupt as Secure and a value of 1 marks it as Non-secure. Downstream distribution logic takes the bits from two outputs. One is a flat vector for the shared interrupts (ID 32 and up). The other carries the private word (IDs 0–31) once for each connected processor.

Only Secure accesses reach the storage. Word 0 is banked, and the requesting-processor index chooses which copy a transfer uses. Words beyond the configured count, bits of unimplemented interrupts, misaligned addresses and addresses outside the window all read as zero, and writes to them are ignored. A processor can be declared Non-secure by parameter, and its private word then resets to all ones. While the lockdown input is high, Secure bits of the lockable shared interrupts cannot change.

Top module: `irq_sec_bank`

## Requirements
- R1: After reset every shared bit is 0 (Secure). The banked word 0 of each processor resets to 0, except that a processor flagged in NS_CPU_MASK gets 1 in every implemented bit.
- R2: Interrupt N sits at byte offset 0x080 + 4*(N/32), bit N%32. Output sharedSec bit i carries interrupt 32+i, and privSec bit c*32+b carries interrupt b of processor c.
- R3: Read data and rdValid appear one cycle after busRd, and rdValid is low in every other cycle. A write takes effect on the clock edge on which busWr is high and replaces the full 32-bit word.
- R4: A transfer with busSecure low returns zero and leaves every stored bit unchanged.
- R5: Word indices at or above LINE_COUNT+1, addresses outside 0x080–0x0FF and addresses with busAddr[1:0] not 0 read as zero and ignore writes.
- R6: Bits of interrupts with ID at or above NUM_IRQS always read as zero and cannot be set.
- R7: Word 0 is banked: a write changes only the copy of the processor given on busCpu, and a read returns that processor's copy.
- R8: With SEC_EXT = 0 every address reads as zero and every write is ignored.
- R9: While lockdown is high during a write, a bit for an interrupt with ID in 32..32+LOCK_COUNT-1 that holds 0 stays 0. Such bits that hold 1, and all other shared bits, stay writable. With lockdown low, all implemented bits are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busSecure | input | 1 | High for a Secure access |
| busCpu | input | CPU_W | Index of the requesting processor |
| lockdown | input | 1 | Freezes Secure lockable shared bits |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRd |
| privSec | output | NUM_CPUS*32 | Per-processor word 0 bits |
| sharedSec | output | NUM_IRQS-32 | Bits for interrupts 32 and up |

## Verification
The assertions check on every cycle that rdValid follows busRd, that Non-secure reads return zero, and that Non-secure writes disturb nothing. They also check that read data never shows an unimplemented bit, that one processor's traffic never moves another processor's word 0, that locked Secure bits never rise, and that an unlocked full-word write lands as written. Reset values, the reset-to-1 word of the Non-secure processor, exact read-back values after combined writes, rejection of out-of-window and misaligned addresses, and the configured-out variant can only be shown by the bench's directed scenarios.

// File: rtl/irq_sec_pkg.sv
package irq_sec_pkg;
  // Decoded strobes passed from control to datapath
  typedef struct packed {
    logic       rdReq;     // read strobe seen
    logic       rdHit;     // read of an accessible implemented word
    logic       wrPriv;    // write to banked word 0
    logic       wrShared;  // write to a shared word
    logic [4:0] wordIdx;   // word index within the window
  } secStrobe_t;
endpackage

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl
  import irq_sec_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WORDS   = 3,
  parameter int SEC_EXT = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busSecure,
  output secStrobe_t        strobes
);
  logic inWindow;
  logic implWord;
  logic allowed;
  logic [4:0] idx;

  always_comb begin
    idx      = busAddr[6:2];
    inWindow = (busAddr[ADDR_W-1:7] == (ADDR_W-7)'(1)) && (busAddr[1:0] == 2'b00);
    implWord = (int'(idx) < WORDS);
    allowed  = (SEC_EXT != 0) && busSecure && inWindow && implWord;

    strobes.rdReq    = busRd;
    strobes.rdHit    = busRd && allowed;
    strobes.wrPriv   = busWr && allowed && (idx == 5'd0);
    strobes.wrShared = busWr && allowed && (idx != 5'd0);
    strobes.wordIdx  = idx;
  end
endmodule

// File: rtl/irq_sec_dpath.sv
module irq_sec_dpath
  import irq_sec_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int CPU_W       = 1,
  parameter int WORDS       = 3,
  parameter int NUM_IRQS    = 80,
  parameter int NS_CPU_MASK = 'b10,
  parameter int LOCK_COUNT  = 16,
  localparam int SHARED_BITS = NUM_IRQS - 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  secStrobe_t               strobes,
  input  logic [CPU_W-1:0]         busCpu,
  input  logic [31:0]              busWdata,
  input  logic                     lockdown,
  output logic [31:0]              rdData,
  output logic                     rdValid,
  output logic [NUM_CPUS*32-1:0]   privSec,
  output logic [SHARED_BITS-1:0]   sharedSec
);
  // Implemented bits of word 0
  function automatic logic [31:0] privImpl();
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (b < NUM_IRQS);
    return m;
  endfunction
  localparam logic [31:0] IMPL0 = privImpl();

  logic [NUM_CPUS-1:0][31:0] privReg;
  logic [SHARED_BITS-1:0]    sharedReg;
  logic [WORDS-1:1][31:0]    sharedView;
  logic [31:0]               readWord;

  // Banked word 0, one copy per processor
  for (genvar c = 0; c < NUM_CPUS; c++) begin : gPriv
    always_ff @(posedge clk) begin
      if (!rstN)
        privReg[c] <= NS_CPU_MASK[c] ? IMPL0 : 32'h0;
      else if (strobes.wrPriv && busCpu == CPU_W'(c))
        privReg[c] <= busWdata & IMPL0;
    end
  end

  // Shared bits, each with its own lock qualification
  for (genvar i = 0; i < SHARED_BITS; i++) begin : gShared
    localparam int ID   = 32 + i;
    localparam int WIDX = ID / 32;
    localparam int BPOS = ID % 32;
    localparam bit LOCKABLE = (ID < 32 + LOCK_COUNT);
    logic bitQ;
    logic frozen;
    assign frozen = LOCKABLE && lockdown && !bitQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        bitQ <= 1'b0;
      else if (strobes.wrShared && strobes.wordIdx == 5'(WIDX) && !frozen)
        bitQ <= busWdata[BPOS];
    end
    assign sharedReg[i] = bitQ;
  end

  always_comb begin
    sharedView = '0;
    for (int i = 0; i < SHARED_BITS; i++)
      sharedView[(32 + i) / 32][(32 + i) % 32] = sharedReg[i];
  end

  always_comb begin
    readWord = '0;
    if (strobes.wordIdx == 5'd0) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (busCpu == CPU_W'(c)) readWord = privReg[c];
    end else begin
      for (int w = 1; w < WORDS; w++)
        if (strobes.wordIdx == 5'(w)) readWord = sharedView[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdReq;
      rdData  <= strobes.rdHit ? readWord : 32'h0;
    end
  end

  assign privSec   = privReg;
  assign sharedSec = sharedReg;
endmodule

// File: rtl/irq_sec_bank.sv
module irq_sec_bank
  import irq_sec_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_CPUS    = 2,
  parameter int LINE_COUNT  = 2,
  parameter int NUM_IRQS    = 80,
  parameter int SEC_EXT     = 1,
  parameter int NS_CPU_MASK = 'b10,
  parameter int LOCK_COUNT  = 16,
  localparam int CPU_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int WORDS       = LINE_COUNT + 1,
  localparam int SHARED_BITS = NUM_IRQS - 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busRd,
  input  logic                   busWr,
  input  logic [31:0]            busWdata,
  input  logic                   busSecure,
  input  logic [CPU_W-1:0]       busCpu,
  input  logic                   lockdown,
  output logic [31:0]            rdData,
  output logic                   rdValid,
  output logic [NUM_CPUS*32-1:0] privSec,
  output logic [SHARED_BITS-1:0] sharedSec
);
  secStrobe_t strobes;

  irq_sec_ctrl #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .SEC_EXT(SEC_EXT)
  ) uCtrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busSecure(busSecure), .strobes(strobes)
  );

  irq_sec_dpath #(
    .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W), .WORDS(WORDS), .NUM_IRQS(NUM_IRQS),
    .NS_CPU_MASK(NS_CPU_MASK), .LOCK_COUNT(LOCK_COUNT)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busCpu(busCpu),
    .busWdata(busWdata), .lockdown(lockdown), .rdData(rdData),
    .rdValid(rdValid), .privSec(privSec), .sharedSec(sharedSec)
  );
endmodule

// File: rtl/irq_sec_bank_chk.sv
module irq_sec_bank_chk #(
  parameter int ADDR_W      = 12,
  parameter int NUM_CPUS    = 2,
  parameter int LINE_COUNT  = 2,
  parameter int NUM_IRQS    = 80,
  parameter int SEC_EXT     = 1,
  parameter int LOCK_COUNT  = 16,
  localparam int CPU_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int WORDS       = LINE_COUNT + 1,
  localparam int SHARED_BITS = NUM_IRQS - 32,
  localparam int S1          = (SHARED_BITS < 32) ? SHARED_BITS : 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busRd,
  input logic                   busWr,
  input logic [31:0]            busWdata,
  input logic                   busSecure,
  input logic [CPU_W-1:0]       busCpu,
  input logic                   lockdown,
  input logic [31:0]            rdData,
  input logic                   rdValid,
  input logic [NUM_CPUS*32-1:0] privSec,
  input logic [SHARED_BITS-1:0] sharedSec
);
  function automatic logic [31:0] implMask(input logic [4:0] w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++)
      m[b] = (int'(w) < WORDS) && (int'(w) * 32 + b < NUM_IRQS);
    return m;
  endfunction

  function automatic logic [SHARED_BITS-1:0] lockMask();
    logic [SHARED_BITS-1:0] m;
    for (int i = 0; i < SHARED_BITS; i++) m[i] = (i < LOCK_COUNT);
    return m;
  endfunction
  localparam logic [SHARED_BITS-1:0] LOCK_MASK = lockMask();

  // R3
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);
  // R3
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid);
  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((SEC_EXT != 0) && busWr && busSecure && !lockdown && busAddr == ADDR_W'('h84))
    |=> sharedSec[S1-1:0] == $past(busWdata[S1-1:0]));
  // R4
  ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busSecure) |=> rdData == 32'h0);
  // R4
  ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busSecure) |=> $stable(sharedSec) && $stable(privSec));
  // R6
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData & ~implMask($past(busAddr[6:2]))) == 32'h0);
  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockdown |=> (~$past(sharedSec) & LOCK_MASK & sharedSec) == '0);

  // R7
  for (genvar c = 0; c < NUM_CPUS; c++) begin : gBank
    bank_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busCpu != CPU_W'(c)) |=> $stable(privSec[c*32 +: 32]));
  end
endmodule

bind irq_sec_bank irq_sec_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_CPUS(NUM_CPUS), .LINE_COUNT(LINE_COUNT),
  .NUM_IRQS(NUM_IRQS), .SEC_EXT(SEC_EXT), .LOCK_COUNT(LOCK_COUNT)
) chkInst (.*);

// File: tb/irq_sec_bank_test.sv
`timescale 1ns/1ps
module irq_sec_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busSecure = 1'b0;
  logic [0:0]  busCpu = '0;
  logic        lockdown = 1'b0;
  logic [31:0] rdData, rdData2;
  logic        rdValid, rdValid2;
  logic [63:0] privSec, privSec2;
  logic [47:0] sharedSec, sharedSec2;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_sec_bank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busSecure(busSecure), .busCpu(busCpu),
    .lockdown(lockdown), .rdData(rdData), .rdValid(rdValid),
    .privSec(privSec), .sharedSec(sharedSec)
  );

  irq_sec_bank #(.SEC_EXT(0)) uut2 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busSecure(busSecure), .busCpu(busCpu),
    .lockdown(lockdown), .rdData(rdData2), .rdValid(rdValid2),
    .privSec(privSec2), .sharedSec(sharedSec2)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d,
                         input logic sec, input logic cpu, input logic lk);
    @(negedge clk);
    busAddr = a; busWdata = d; busSecure = sec; busCpu = cpu; lockdown = lk;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; lockdown = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic sec, input logic cpu,
                        output logic [31:0] d, output logic [31:0] d2);
    @(negedge clk);
    busAddr = a; busSecure = sec; busCpu = cpu; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = rdData; d2 = rdData2;
    check("R3 rdValid after read", 64'(rdValid), 64'd1);
  endtask

  task automatic testReset();
    logic [31:0] d, d2;
    check("R3 rdValid idle after reset", 64'(rdValid), 64'd0);
    check("R1 privSec reset", privSec, {32'hFFFF_FFFF, 32'h0});
    check("R1 sharedSec reset", 64'(sharedSec), 64'h0);
    doRead(12'h080, 1'b1, 1'b0, d, d2);
    check("R1 cpu0 word0 reset", 64'(d), 64'h0);
    @(negedge clk);
    check("R3 rdValid drops", 64'(rdValid), 64'd0);
    doRead(12'h080, 1'b1, 1'b1, d, d2);
    check("R1 cpu1 word0 reset ones", 64'(d), 64'hFFFF_FFFF);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R1 word1 reset", 64'(d), 64'h0);
  endtask

  task automatic testBasic();
    logic [31:0] d, d2;
    doWrite(12'h084, 32'hA5A5_0F0F, 1'b1, 1'b0, 1'b0);
    check("R2 sharedSec word1 bits", 64'(sharedSec[31:0]), 64'hA5A5_0F0F);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R3 word1 readback", 64'(d), 64'hA5A5_0F0F);
    doWrite(12'h088, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    doRead(12'h088, 1'b1, 1'b0, d, d2);
    check("R6 unimplemented bits zero", 64'(d), 64'h0000_FFFF);
    check("R2 sharedSec ids 64-79", 64'(sharedSec[47:32]), 64'hFFFF);
  endtask

  task automatic testBanking();
    logic [31:0] d, d2;
    doWrite(12'h080, 32'h1234_5678, 1'b1, 1'b0, 1'b0);
    doRead(12'h080, 1'b1, 1'b0, d, d2);
    check("R7 cpu0 own copy", 64'(d), 64'h1234_5678);
    doRead(12'h080, 1'b1, 1'b1, d, d2);
    check("R7 cpu1 untouched", 64'(d), 64'hFFFF_FFFF);
    doWrite(12'h080, 32'h0000_0000, 1'b1, 1'b1, 1'b0);
    check("R7 privSec both copies", privSec, {32'h0, 32'h1234_5678});
  endtask

  task automatic testNonSecure();
    logic [31:0] d, d2;
    doWrite(12'h084, 32'h0, 1'b0, 1'b0, 1'b0);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R4 ns write ignored", 64'(d), 64'hA5A5_0F0F);
    doRead(12'h084, 1'b0, 1'b0, d, d2);
    check("R4 ns read zero", 64'(d), 64'h0);
  endtask

  task automatic testRange();
    logic [31:0] d, d2;
    doWrite(12'h08C, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    doRead(12'h08C, 1'b1, 1'b0, d, d2);
    check("R5 word3 reads zero", 64'(d), 64'h0);
    doRead(12'h100, 1'b1, 1'b0, d, d2);
    check("R5 outside window zero", 64'(d), 64'h0);
    doWrite(12'h086, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R5 misaligned write ignored", 64'(sharedSec), {16'hFFFF, 32'hA5A5_0F0F});
    doRead(12'h085, 1'b1, 1'b0, d, d2);
    check("R5 misaligned read zero", 64'(d), 64'h0);
  endtask

  task automatic testLock();
    logic [31:0] d, d2;
    doWrite(12'h084, 32'h0000_00F0, 1'b1, 1'b0, 1'b0);
    doWrite(12'h084, 32'hFFFF_FF0F, 1'b1, 1'b0, 1'b1);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R9 locked secure bits held", 64'(d), 64'hFFFF_0000);
    doWrite(12'h088, 32'h0, 1'b1, 1'b0, 1'b1);
    doRead(12'h088, 1'b1, 1'b0, d, d2);
    check("R9 unlockable word writable", 64'(d), 64'h0);
    doWrite(12'h084, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R9 writable after release", 64'(d), 64'h0000_FFFF);
  endtask

  task automatic testNoSecExt();
    logic [31:0] d, d2;
    doWrite(12'h084, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    doRead(12'h084, 1'b1, 1'b0, d, d2);
    check("R8 configured-out read zero", 64'(d2), 64'h0);
    check("R8 configured-out write ignored", 64'(sharedSec2), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testBanking();
    testNonSecure();
    testRange();
    testLock();
    testNoSecExt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule